// File: doc/BRIEF.md
# MESI Snooping Coherence Controller

This block tracks the coherence state of every line in one processor's small private cache on a shared snooping bus. Each line is Invalid, Shared, Exclusive or Modified. The processor side presents one request at a time: read, write or evict. Each request names a line index. Requests that the cache can satisfy locally complete in the cycle they are accepted. A request that needs the bus raises a busy flag and drives a bus read, bus write or bus upgrade command. The command stays on the bus until the arbiter grants it. In the grant cycle, a sharer input picks between Exclusive and Shared for a read fill.

On the bus side, the block watches the commands that other caches issue. For the addressed line it returns a shared or dirty indication in the same cycle. When the line holds modified data, it raises a writeback strobe together with the line index, and it updates the line state at the next clock edge. An upgrade that arrives for a line this cache owns cannot happen under a correct protocol, so the block flags it as an error. The data arrays, the bus arbiter and memory lie outside this block. Data movement is visible only as the writeback strobe.

A snoop always wins over a local request to the same line in the same cycle. If a pending upgrade loses its Shared copy to a snoop before the grant arrives, the block reissues the request as a full bus write.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid. The block reports line states on `req_state` with the encoding I=00, S=01, E=10, M=11. After reset `busy` is 0 and `bus_cmd` is 0.
- R2: A read (`req_op`=0) to an Invalid line is accepted. From the next cycle `busy` is 1 and `bus_cmd`=1 (bus read), with `bus_line` set to the line. These hold until a cycle with `bus_grant`=1. At that edge the line becomes E if `bus_shared_in`=0 and S if it is 1, and `busy` falls.
- R3: A write (`req_op`=1) to an Invalid line drives `bus_cmd`=2 (bus write) while busy. At the grant the line becomes M.
- R4: A write to a Shared line drives `bus_cmd`=3 (bus upgrade) while busy, and the line becomes M at the grant. If a snoop invalidates the line while the upgrade waits, the command changes to 2 (bus write) from the next cycle.
- R5: A write to an Exclusive line makes it M at the next edge with no bus command and no busy cycle. Reads to S, E or M lines and writes to M lines leave the state unchanged and issue no bus command.
- R6: An eviction (`req_op`=2) of an M line raises `wb_valid`, with `wb_line` set to the line, in the accept cycle, and the line becomes Invalid. An eviction of an S or E line makes it Invalid with no writeback.
- R7: A snooped bus read (`snoop_cmd`=1) on an S or E line raises `snoop_shared` in the same cycle and leaves the line S. On an M line it raises `snoop_dirty` and `wb_valid`, and the line becomes S.
- R8: A snooped bus write (`snoop_cmd`=2) makes an S or E line Invalid with no response. On an M line it raises `snoop_dirty` and `wb_valid`, and the line becomes Invalid.
- R9: A snooped bus upgrade (`snoop_cmd`=3) makes an S line Invalid. On an E or M line it raises `proto_err` in the same cycle and leaves the state unchanged. A snoop to an Invalid line gives no response and changes nothing.
- R10: When a snoop addresses the same line as a local request in the same cycle, `req_ready` is 0 and the snoop takes effect. A local eviction that would write back is also held off when the snoop of another line writes back in that cycle.
- R11: While `busy` is 1, `req_ready` is 0 and no further request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Local request present |
| req_op | input | 2 | Local operation: 0 read, 1 write, 2 evict, 3 no operation |
| req_line | input | IDX_W | Line index of the local request |
| req_ready | output | 1 | Local request accepted this cycle |
| req_state | output | 2 | Current state of line `req_line` |
| busy | output | 1 | A bus transaction is waiting for its grant |
| bus_cmd | output | 2 | Issued command: 0 none, 1 read, 2 write, 3 upgrade |
| bus_line | output | IDX_W | Line index of the issued command |
| bus_grant | input | 1 | The issued command completes this cycle |
| bus_shared_in | input | 1 | Another cache holds the line (sampled at grant) |
| snoop_valid | input | 1 | Snooped command present |
| snoop_cmd | input | 2 | Snooped command: 1 read, 2 write, 3 upgrade |
| snoop_line | input | IDX_W | Line index of the snooped command |
| snoop_shared | output | 1 | This cache holds a clean copy |
| snoop_dirty | output | 1 | This cache holds modified data |
| wb_valid | output | 1 | Writeback strobe |
| wb_line | output | IDX_W | Line index of the writeback |
| proto_err | output | 1 | Upgrade snooped on an E or M line |

## Verification
Snoop responses, the writeback strobe, `req_ready` and the error flag are combinational. The bench drives its inputs at the falling edge and samples these outputs two nanoseconds later, inside the same cycle. Line states and `busy` change at the rising edge that follows acceptance, a grant or a snoop. The bench reads them through `req_state` at the next falling edge. The bus command first appears one edge after acceptance. It is checked in that cycle, in later cycles without a grant, and again after a snoop has changed the pending line.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'b00,
        ST_S = 2'b01,
        ST_E = 2'b10,
        ST_M = 2'b11
    } mesi_state_t;

    typedef enum logic [1:0] {
        LOP_RD  = 2'd0,
        LOP_WR  = 2'd1,
        LOP_EV  = 2'd2,
        LOP_NOP = 2'd3
    } lcl_op_t;

    typedef enum logic [1:0] {
        BUS_NONE = 2'd0,
        BUS_RD   = 2'd1,
        BUS_WR   = 2'd2,
        BUS_UPG  = 2'd3
    } bus_cmd_t;

endpackage

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
    import mesi_pkg::*;
(
    input  logic        act_i,
    input  bus_cmd_t    cmd_i,
    input  mesi_state_t st_i,
    output logic        shared_o,
    output logic        dirty_o,
    output logic        wb_o,
    output logic        err_o,
    output logic        upd_o,
    output mesi_state_t st_o
);

    always_comb begin
        shared_o = 1'b0;
        dirty_o  = 1'b0;
        wb_o     = 1'b0;
        err_o    = 1'b0;
        upd_o    = 1'b0;
        st_o     = st_i;
        if (act_i) begin
            case (cmd_i)
                BUS_RD: begin
                    case (st_i)
                        ST_S: shared_o = 1'b1;
                        ST_E: begin
                            shared_o = 1'b1;
                            st_o     = ST_S;
                            upd_o    = 1'b1;
                        end
                        ST_M: begin
                            dirty_o = 1'b1;
                            wb_o    = 1'b1;
                            st_o    = ST_S;
                            upd_o   = 1'b1;
                        end
                        default: ;
                    endcase
                end
                BUS_WR: begin
                    case (st_i)
                        ST_S, ST_E: begin
                            st_o  = ST_I;
                            upd_o = 1'b1;
                        end
                        ST_M: begin
                            dirty_o = 1'b1;
                            wb_o    = 1'b1;
                            st_o    = ST_I;
                            upd_o   = 1'b1;
                        end
                        default: ;
                    endcase
                end
                BUS_UPG: begin
                    case (st_i)
                        ST_S: begin
                            st_o  = ST_I;
                            upd_o = 1'b1;
                        end
                        ST_E, ST_M: err_o = 1'b1;
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mesi_local_ctrl.sv
module mesi_local_ctrl
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid_i,
    input  lcl_op_t                       req_op_i,
    input  logic [IDX_W-1:0]              req_line_i,
    input  mesi_state_t [NUM_LINES-1:0]   states_i,
    input  logic                          snp_act_i,
    input  logic [IDX_W-1:0]              snp_line_i,
    input  logic                          snp_wb_i,
    input  logic                          grant_i,
    input  logic                          shared_i,
    output logic                          req_ready_o,
    output logic                          busy_o,
    output bus_cmd_t                      bus_cmd_o,
    output logic [IDX_W-1:0]              bus_line_o,
    output logic [IDX_W-1:0]              lcl_line_o,
    output logic                          lcl_we_o,
    output mesi_state_t                   lcl_st_o,
    output logic                          evict_wb_o
);

    typedef struct packed {
        logic             waiting;
        lcl_op_t          op;
        logic [IDX_W-1:0] line;
    } pend_t;

    pend_t       pend_q, pend_d;
    mesi_state_t cur_st;
    logic        same_line;

    always_comb begin
        pend_d      = pend_q;
        req_ready_o = 1'b0;
        busy_o      = 1'b0;
        bus_cmd_o   = BUS_NONE;
        bus_line_o  = pend_q.line;
        lcl_we_o    = 1'b0;
        lcl_st_o    = ST_I;
        evict_wb_o  = 1'b0;
        lcl_line_o  = pend_q.waiting ? pend_q.line : req_line_i;
        cur_st      = states_i[lcl_line_o];
        same_line   = snp_act_i && (snp_line_i == lcl_line_o);

        if (!pend_q.waiting) begin
            req_ready_o = !same_line &&
                          !(snp_wb_i && req_op_i == LOP_EV && cur_st == ST_M);
            if (req_valid_i && req_ready_o) begin
                case (req_op_i)
                    LOP_RD: begin
                        if (cur_st == ST_I) begin
                            pend_d.waiting = 1'b1;
                            pend_d.op      = LOP_RD;
                            pend_d.line    = req_line_i;
                        end
                    end
                    LOP_WR: begin
                        case (cur_st)
                            ST_I, ST_S: begin
                                pend_d.waiting = 1'b1;
                                pend_d.op      = LOP_WR;
                                pend_d.line    = req_line_i;
                            end
                            ST_E: begin
                                lcl_we_o = 1'b1;
                                lcl_st_o = ST_M;
                            end
                            default: ;
                        endcase
                    end
                    LOP_EV: begin
                        if (cur_st != ST_I) begin
                            lcl_we_o   = 1'b1;
                            lcl_st_o   = ST_I;
                            evict_wb_o = (cur_st == ST_M);
                        end
                    end
                    default: ;
                endcase
            end
        end else begin
            busy_o = 1'b1;
            if (pend_q.op == LOP_RD) begin
                bus_cmd_o = BUS_RD;
            end else begin
                bus_cmd_o = (cur_st == ST_S) ? BUS_UPG : BUS_WR;
            end
            if (grant_i && !same_line) begin
                lcl_we_o       = 1'b1;
                pend_d.waiting = 1'b0;
                if (pend_q.op == LOP_RD) begin
                    lcl_st_o = shared_i ? ST_S : ST_E;
                end else begin
                    lcl_st_o = ST_M;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    // R11: no request is taken while a bus transaction waits
    a_r11_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !req_ready_o);

    // R2: busy holds until a grant arrives
    a_r2_busy_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !grant_i) |=> busy_o);

    // R2: busy only starts after an accepted request
    a_r2_busy_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(req_valid_i && req_ready_o));

    // R5: a bus command is driven only while busy
    a_r5_cmd_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_o != BUS_NONE) |-> busy_o);

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [IDX_W-1:0] req_line,
    output logic             req_ready,
    output logic [1:0]       req_state,
    output logic             busy,
    output logic [1:0]       bus_cmd,
    output logic [IDX_W-1:0] bus_line,
    input  logic             bus_grant,
    input  logic             bus_shared_in,
    input  logic             snoop_valid,
    input  logic [1:0]       snoop_cmd,
    input  logic [IDX_W-1:0] snoop_line,
    output logic             snoop_shared,
    output logic             snoop_dirty,
    output logic             wb_valid,
    output logic [IDX_W-1:0] wb_line,
    output logic             proto_err
);

    typedef struct packed {
        mesi_state_t [NUM_LINES-1:0] lines;
    } regs_t;

    regs_t            regs_q, regs_d;
    mesi_state_t      nxt_line [NUM_LINES];

    logic             snp_act;
    logic             snp_wb;
    logic             snp_upd;
    mesi_state_t      snp_st;
    logic [IDX_W-1:0] lcl_line;
    logic             lcl_we;
    mesi_state_t      lcl_st;
    logic             evict_wb;
    bus_cmd_t         bus_cmd_e;

    assign snp_act = snoop_valid && (bus_cmd_t'(snoop_cmd) != BUS_NONE);

    mesi_snoop_resp u_snoop (
        .act_i    (snp_act),
        .cmd_i    (bus_cmd_t'(snoop_cmd)),
        .st_i     (regs_q.lines[snoop_line]),
        .shared_o (snoop_shared),
        .dirty_o  (snoop_dirty),
        .wb_o     (snp_wb),
        .err_o    (proto_err),
        .upd_o    (snp_upd),
        .st_o     (snp_st)
    );

    mesi_local_ctrl #(.NUM_LINES(NUM_LINES)) u_local (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .req_op_i    (lcl_op_t'(req_op)),
        .req_line_i  (req_line),
        .states_i    (regs_q.lines),
        .snp_act_i   (snp_act),
        .snp_line_i  (snoop_line),
        .snp_wb_i    (snp_wb),
        .grant_i     (bus_grant),
        .shared_i    (bus_shared_in),
        .req_ready_o (req_ready),
        .busy_o      (busy),
        .bus_cmd_o   (bus_cmd_e),
        .bus_line_o  (bus_line),
        .lcl_line_o  (lcl_line),
        .lcl_we_o    (lcl_we),
        .lcl_st_o    (lcl_st),
        .evict_wb_o  (evict_wb)
    );

    assign bus_cmd   = bus_cmd_e;
    assign req_state = regs_q.lines[req_line];
    assign wb_valid  = snp_wb || evict_wb;
    assign wb_line   = snp_wb ? snoop_line : lcl_line;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        always_comb begin
            nxt_line[i] = regs_q.lines[i];
            if (snp_upd && snoop_line == IDX_W'(i)) begin
                nxt_line[i] = snp_st;
            end else if (lcl_we && lcl_line == IDX_W'(i)) begin
                nxt_line[i] = lcl_st;
            end
        end
    end

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NUM_LINES; i++) begin
            regs_d.lines[i] = nxt_line[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // R7: a snoop never reports clean and dirty together
    a_r7_resp_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(snoop_shared && snoop_dirty));

    // R8: a dirty response always carries a writeback of the snooped line
    a_r8_dirty_writes_back: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_dirty |-> (wb_valid && wb_line == snoop_line));

    // R9: the error flag comes only from a snooped upgrade
    a_r9_err_from_upgrade: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> (snoop_valid && snoop_cmd == 2'd3));

    // R9: an erroneous upgrade leaves the line state alone
    a_r9_err_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> (regs_q.lines[$past(snoop_line)] == $past(regs_q.lines[snoop_line])));

    // R6: every writeback has a snoop or an accepted eviction behind it
    a_r6_wb_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (snoop_dirty || (req_valid && req_ready && req_op == 2'd2)));

endmodule

// File: tb/sim_mesi_snoop_ctrl.sv
module sim_mesi_snoop_ctrl;

    localparam int LINES = 8;
    localparam int LW    = $clog2(LINES);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'd0;
    logic [LW-1:0] req_line = '0;
    logic          req_ready;
    logic [1:0]    req_state;
    logic          busy;
    logic [1:0]    bus_cmd;
    logic [LW-1:0] bus_line;
    logic          bus_grant = 1'b0;
    logic          bus_shared_in = 1'b0;
    logic          snoop_valid = 1'b0;
    logic [1:0]    snoop_cmd = 2'd0;
    logic [LW-1:0] snoop_line = '0;
    logic          snoop_shared;
    logic          snoop_dirty;
    logic          wb_valid;
    logic [LW-1:0] wb_line;
    logic          proto_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int s_ready, s_wb, s_wbl, s_sh, s_dr, s_err;

    always #10 clk = ~clk;

    mesi_snoop_ctrl #(.NUM_LINES(LINES)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_line(req_line),
        .req_ready(req_ready), .req_state(req_state), .busy(busy),
        .bus_cmd(bus_cmd), .bus_line(bus_line),
        .bus_grant(bus_grant), .bus_shared_in(bus_shared_in),
        .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd), .snoop_line(snoop_line),
        .snoop_shared(snoop_shared), .snoop_dirty(snoop_dirty),
        .wb_valid(wb_valid), .wb_line(wb_line), .proto_err(proto_err)
    );

    localparam logic [1:0] SI = 2'd0, SS = 2'd1, SE = 2'd2, SM = 2'd3;
    localparam logic [1:0] RD = 2'd0, WR = 2'd1, EV = 2'd2;
    localparam logic [1:0] BN = 2'd0, BR = 2'd1, BW = 2'd2, BU = 2'd3;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one clock with the given inputs; combinational outputs captured mid-cycle
    task automatic cyc(input logic rv, input logic [1:0] op, input int rl,
                       input logic sv, input logic [1:0] sc, input int sl,
                       input logic g, input logic sh);
        @(negedge clk);
        req_valid = rv; req_op = op; req_line = LW'(rl);
        snoop_valid = sv; snoop_cmd = sc; snoop_line = LW'(sl);
        bus_grant = g; bus_shared_in = sh;
        #2;
        s_ready = int'(req_ready); s_wb = int'(wb_valid); s_wbl = int'(wb_line);
        s_sh = int'(snoop_shared); s_dr = int'(snoop_dirty); s_err = int'(proto_err);
        @(posedge clk);
        #1;
        req_valid = 1'b0; snoop_valid = 1'b0; bus_grant = 1'b0; bus_shared_in = 1'b0;
    endtask

    task automatic lreq(input logic [1:0] op, input int line);
        cyc(1'b1, op, line, 1'b0, BN, 0, 1'b0, 1'b0);
    endtask

    task automatic snp(input logic [1:0] c, input int line);
        cyc(1'b0, RD, 0, 1'b1, c, line, 1'b0, 1'b0);
    endtask

    task automatic grant(input logic sh);
        cyc(1'b0, RD, 0, 1'b0, BN, 0, 1'b1, sh);
    endtask

    task automatic expect_st(input int line, input logic [1:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1'b0; req_line = LW'(line);
        #2;
        chk(tag, int'(req_state), int'(exp));
    endtask

    task automatic expect_bus(input int b, input int c, input int l, input string tag);
        @(negedge clk);
        #2;
        chk({tag, " busy"}, int'(busy), b);
        chk({tag, " cmd"}, int'(bus_cmd), c);
        if (c != 0) chk({tag, " line"}, int'(bus_line), l);
    endtask

    task automatic fill(input logic [1:0] op, input int line, input logic sh);
        lreq(op, line);
        grant(sh);
    endtask

    task automatic t_reset;
        for (int i = 0; i < LINES; i++) expect_st(i, SI, "R1 reset state");
        expect_bus(0, 0, 0, "R1 reset");
    endtask

    task automatic t_read_miss;
        lreq(RD, 1);
        chk("R2 read miss ready", s_ready, 1);
        expect_bus(1, 1, 1, "R2 read pending");
        expect_bus(1, 1, 1, "R2 read still pending");
        grant(1'b0);
        expect_st(1, SE, "R2 fill no sharer");
        expect_bus(0, 0, 0, "R2 after grant");
        fill(RD, 2, 1'b1);
        expect_st(2, SS, "R2 fill with sharer");
    endtask

    task automatic t_silent_and_hits;
        lreq(WR, 1);
        chk("R5 write E ready", s_ready, 1);
        expect_bus(0, 0, 0, "R5 silent upgrade");
        expect_st(1, SM, "R5 E to M");
        lreq(RD, 1);
        lreq(WR, 1);
        lreq(RD, 2);
        expect_bus(0, 0, 0, "R5 hits no bus");
        expect_st(1, SM, "R5 hit M unchanged");
        expect_st(2, SS, "R5 hit S unchanged");
    endtask

    task automatic t_write_miss;
        lreq(WR, 3);
        expect_bus(1, 2, 3, "R3 write miss");
        grant(1'b1);
        expect_st(3, SM, "R3 write fill");
    endtask

    task automatic t_upgrade;
        lreq(WR, 2);
        expect_bus(1, 3, 2, "R4 upgrade");
        grant(1'b1);
        expect_st(2, SM, "R4 S to M");
        fill(RD, 4, 1'b1);
        lreq(WR, 4);
        expect_bus(1, 3, 4, "R4 upgrade pending");
        snp(BW, 4);
        expect_st(4, SI, "R4 lost copy");
        expect_bus(1, 2, 4, "R4 reissued as write");
        grant(1'b0);
        expect_st(4, SM, "R4 write after loss");
    endtask

    task automatic t_evict;
        lreq(EV, 3);
        chk("R6 evict M wb", s_wb, 1);
        chk("R6 evict M wb line", s_wbl, 3);
        expect_st(3, SI, "R6 evict M state");
        fill(RD, 5, 1'b0);
        expect_st(5, SE, "R6 setup E");
        lreq(EV, 5);
        chk("R6 evict E no wb", s_wb, 0);
        expect_st(5, SI, "R6 evict E state");
    endtask

    task automatic t_snoop_read;
        fill(RD, 5, 1'b0);
        snp(BR, 5);
        chk("R7 BR on E shared", s_sh, 1);
        chk("R7 BR on E dirty", s_dr, 0);
        chk("R7 BR on E wb", s_wb, 0);
        expect_st(5, SS, "R7 E to S");
        snp(BR, 5);
        chk("R7 BR on S shared", s_sh, 1);
        expect_st(5, SS, "R7 S stays");
        snp(BR, 1);
        chk("R7 BR on M dirty", s_dr, 1);
        chk("R7 BR on M shared", s_sh, 0);
        chk("R7 BR on M wb", s_wb, 1);
        chk("R7 BR on M wb line", s_wbl, 1);
        expect_st(1, SS, "R7 M to S");
    endtask

    task automatic t_snoop_write;
        snp(BW, 1);
        chk("R8 BW on S response", s_sh + s_dr + s_wb, 0);
        expect_st(1, SI, "R8 S to I");
        fill(WR, 6, 1'b0);
        snp(BW, 6);
        chk("R8 BW on M dirty", s_dr, 1);
        chk("R8 BW on M wb", s_wb, 1);
        chk("R8 BW on M wb line", s_wbl, 6);
        expect_st(6, SI, "R8 M to I");
        fill(RD, 7, 1'b0);
        snp(BW, 7);
        chk("R8 BW on E response", s_sh + s_dr + s_wb, 0);
        expect_st(7, SI, "R8 E to I");
    endtask

    task automatic t_snoop_upgrade;
        snp(BU, 2);
        chk("R9 BU on M err", s_err, 1);
        expect_st(2, SM, "R9 M kept");
        fill(RD, 0, 1'b0);
        snp(BU, 0);
        chk("R9 BU on E err", s_err, 1);
        expect_st(0, SE, "R9 E kept");
        snp(BR, 0);
        snp(BU, 0);
        chk("R9 BU on S err", s_err, 0);
        expect_st(0, SI, "R9 S to I");
        snp(BR, 6);
        chk("R9 snoop I response", s_sh + s_dr + s_wb + s_err, 0);
        expect_st(6, SI, "R9 I unchanged");
    endtask

    task automatic t_priority;
        cyc(1'b1, RD, 0, 1'b1, BW, 0, 1'b0, 1'b0);
        chk("R10 same line blocks", s_ready, 0);
        expect_bus(0, 0, 0, "R10 blocked not taken");
        cyc(1'b1, RD, 0, 1'b1, BR, 5, 1'b0, 1'b0);
        chk("R10 other line ready", s_ready, 1);
        chk("R10 snoop resp same cycle", s_sh, 1);
        grant(1'b0);
        expect_st(0, SE, "R10 request completed");
        cyc(1'b1, EV, 2, 1'b1, BR, 4, 1'b0, 1'b0);
        chk("R10 wb clash blocks", s_ready, 0);
        chk("R10 snoop wb line", s_wbl, 4);
        expect_st(2, SM, "R10 evict held off");
        expect_st(4, SS, "R10 snoop applied");
    endtask

    task automatic t_busy_block;
        lreq(RD, 7);
        lreq(WR, 1);
        chk("R11 ready low while busy", s_ready, 0);
        expect_bus(1, 1, 7, "R11 still pending");
        grant(1'b0);
        expect_st(7, SE, "R11 fill done");
        expect_st(1, SI, "R11 second request dropped");
        expect_bus(0, 0, 0, "R11 idle again");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_read_miss();
        t_silent_and_hits();
        t_write_miss();
        t_upgrade();
        t_evict();
        t_snoop_read();
        t_snoop_write();
        t_snoop_upgrade();
        t_priority();
        t_busy_block();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule